// File: doc/BRIEF.md
# Vector-Addressed Configuration Row Loader

The loader accepts an 8-bit configuration byte stream and makes partial updates to a frame store. The frame store is organised as blocks, and each block holds eight frames. A row is the set of eight bytes at one offset across the eight frames of a block. A transfer opens with a two-byte header: a starting block and a count of consecutive blocks. For every row of every block covered, the stream then carries one selection byte, followed only by the replacement bytes that the selection asks for.

For each row that has a non-zero selection, the loader performs a read-modify-write. It copies the current row into an 8-byte staging register, patches only the selected lanes, and writes the row back. Rows with an all-zero selection cost one port byte and involve no storage access. The port uses a valid/ready handshake. Ready drops while a row is read or written back. A single-cycle completion pulse follows the last row of the last block. A combinational peek port exposes any stored row so that the contents can be observed.

Top module: `cfgv_loader`

## Requirements
- R1: After reset the loader waits for a header, cfg_ready_o is 1, done_o is 0, and every stored row reads as zero on the peek port.
- R2: The first header byte selects the starting block. Only its low log2(NUM_BLOCKS) bits are used, and the upper bits are ignored. The second header byte is the number of consecutive blocks. Block numbers wrap from NUM_BLOCKS-1 to 0.
- R3: A block count of zero pulses done_o in the cycle after the count byte is taken. No row bytes are expected, and the storage is left unchanged.
- R4: Bit i of a selection byte selects lane i of the row, which is frame i of the block and appears on bits 8i+7:8i of peek_row_o. The selected replacement bytes follow the selection byte in ascending lane order.
- R5: Lanes that are not selected keep their previous stored value after the row is written back.
- R6: A selection byte of zero skips the row: the next byte taken is the selection byte of the following row, with no cycle of ready low in between.
- R7: After a non-zero selection byte is taken, cfg_ready_o is low for exactly one cycle (row read). After the last selected replacement byte is taken, it is low for exactly one cycle (write-back).
- R8: Rows are visited from offset 0 to FRAME_BYTES-1 within a block, and then the next consecutive block is started at offset 0.
- R9: done_o is a single-cycle pulse in the cycle after the final row completes, where completion is the write-back or a zero selection byte. In that same cycle the loader already accepts the first byte of a new header.
- R10: A byte offered while cfg_ready_o is low is not consumed, and it is taken unchanged once ready returns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cfg_valid_i | input | 1 | Stream byte valid |
| cfg_data_i | input | 8 | Stream byte |
| cfg_ready_o | output | 1 | Loader can take a byte this cycle |
| done_o | output | 1 | Transfer complete pulse |
| peek_blk_i | input | log2(NUM_BLOCKS) | Block to observe |
| peek_row_i | input | log2(FRAME_BYTES) | Row offset to observe |
| peek_row_o | output | 64 | Stored row, lane i on bits 8i+7:8i; zero when out of range |

## Verification
Two events can fall in the same cycle: the completion pulse of one transfer and the acceptance of the first header byte of the next. The bench provokes this by ending a transfer on a row with a non-zero selection and then offering the next header back-to-back, with no idle cycle. It then checks that exactly one pulse was seen and that the second transfer lands in the block named by its header. The bench also verifies the exact stall cycles around row reads and write-backs, as well as skip rows, block wrap and zero counts. All of these directed cases are mixed with seeded random transfers that include random idle gaps.

// File: rtl/cfgv_pkg.sv
package cfgv_pkg;
  localparam int LANES    = 8;
  localparam int LANE_W   = 3;
  localparam int ROW_BITS = LANES * 8;

  typedef enum logic [2:0] {
    ST_HDR_ADDR,
    ST_HDR_CNT,
    ST_VEC,
    ST_READ,
    ST_DATA,
    ST_WRITE
  } cfgv_state_e;

  // lowest set lane of a selection byte
  function automatic logic [LANE_W-1:0] low_lane(input logic [LANES-1:0] v);
    logic [LANE_W-1:0] l;
    l = '0;
    for (int i = LANES - 1; i >= 0; i--) begin
      if (v[i]) l = LANE_W'(i);
    end
    return l;
  endfunction
endpackage

// File: rtl/cfgv_frame_store.sv
module cfgv_frame_store #(
  parameter int DEPTH    = 448,
  parameter int ROW_BITS = 64,
  localparam int IDX_W   = $clog2(DEPTH)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                wr_i,
  input  logic [IDX_W-1:0]    wr_idx_i,
  input  logic [ROW_BITS-1:0] wr_row_i,
  input  logic [IDX_W-1:0]    rd_idx_i,
  output logic [ROW_BITS-1:0] rd_row_o,
  input  logic [IDX_W-1:0]    peek_idx_i,
  output logic [ROW_BITS-1:0] peek_row_o
);
  logic [ROW_BITS-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (wr_i) begin
      mem_q[wr_idx_i] <= wr_row_i;
    end
  end

  assign rd_row_o   = mem_q[rd_idx_i];
  assign peek_row_o = (int'(peek_idx_i) < DEPTH) ? mem_q[peek_idx_i] : '0;

  // a write-back is always preceded by a selection or data cycle
  assert_wr_isolated_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> !wr_i);
endmodule

// File: rtl/cfgv_row_stage.sv
module cfgv_row_stage import cfgv_pkg::*; (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                ld_i,
  input  logic [ROW_BITS-1:0] row_i,
  input  logic                put_i,
  input  logic [LANE_W-1:0]   lane_i,
  input  logic [7:0]          byte_i,
  output logic [ROW_BITS-1:0] row_o
);
  logic [ROW_BITS-1:0] stage_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stage_q <= '0;
    end else if (ld_i) begin
      stage_q <= row_i;
    end else if (put_i) begin
      stage_q[{lane_i, 3'b000} +: 8] <= byte_i;
    end
  end

  assign row_o = stage_q;

  assert_load_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld_i |=> row_o == $past(row_i));

  for (genvar l = 0; l < LANES; l++) begin : g_keep
    assert_keep_lane_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (put_i && !ld_i && lane_i != LANE_W'(l)) |=> row_o[l*8 +: 8] == $past(row_o[l*8 +: 8]));
  end
endmodule

// File: rtl/cfgv_seq.sv
module cfgv_seq import cfgv_pkg::*; #(
  parameter int NUM_BLOCKS  = 8,
  parameter int FRAME_BYTES = 56,
  localparam int BLK_W      = $clog2(NUM_BLOCKS),
  localparam int ROW_W      = $clog2(FRAME_BYTES),
  localparam int IDX_W      = $clog2(NUM_BLOCKS * FRAME_BYTES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [7:0]        data_i,
  output logic              ready_o,
  output logic              done_o,
  output logic              ld_o,
  output logic              put_o,
  output logic [LANE_W-1:0] lane_o,
  output logic              wr_o,
  output logic [IDX_W-1:0]  idx_o
);
  cfgv_state_e       st_q;
  logic [BLK_W-1:0]  blk_q;
  logic [7:0]        left_q;
  logic [ROW_W-1:0]  row_q;
  logic [LANES-1:0]  vec_q;
  logic              done_q;

  logic fire, last_row, last_blk, row_done, last_sel;
  logic [LANES-1:0] lane_mask;
  logic [BLK_W-1:0] blk_nxt;

  assign ready_o  = (st_q == ST_HDR_ADDR) || (st_q == ST_HDR_CNT) ||
                    (st_q == ST_VEC) || (st_q == ST_DATA);
  assign fire     = valid_i && ready_o;
  assign last_row = (row_q == ROW_W'(FRAME_BYTES - 1));
  assign last_blk = (left_q == 8'd0);
  assign lane_o   = low_lane(vec_q);
  assign lane_mask = LANES'(1) << lane_o;
  assign last_sel = ((vec_q & (vec_q - LANES'(1))) == '0);
  assign blk_nxt  = (blk_q == BLK_W'(NUM_BLOCKS - 1)) ? '0 : blk_q + BLK_W'(1);
  assign row_done = (st_q == ST_WRITE) || (st_q == ST_VEC && fire && data_i == 8'd0);

  assign ld_o   = (st_q == ST_READ);
  assign wr_o   = (st_q == ST_WRITE);
  assign put_o  = (st_q == ST_DATA) && fire;
  assign idx_o  = IDX_W'(blk_q) * IDX_W'(FRAME_BYTES) + IDX_W'(row_q);
  assign done_o = done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_HDR_ADDR;
      blk_q  <= '0;
      left_q <= '0;
      row_q  <= '0;
      vec_q  <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (st_q)
        ST_HDR_ADDR: if (fire) begin
          blk_q <= data_i[BLK_W-1:0];
          st_q  <= ST_HDR_CNT;
        end
        ST_HDR_CNT: if (fire) begin
          row_q <= '0;
          if (data_i == 8'd0) begin
            done_q <= 1'b1;
            st_q   <= ST_HDR_ADDR;
          end else begin
            left_q <= data_i - 8'd1;
            st_q   <= ST_VEC;
          end
        end
        ST_VEC: if (fire && data_i != 8'd0) begin
          vec_q <= data_i;
          st_q  <= ST_READ;
        end
        ST_READ: st_q <= ST_DATA;
        ST_DATA: if (fire) begin
          vec_q <= vec_q & ~lane_mask;
          if (last_sel) st_q <= ST_WRITE;
        end
        ST_WRITE: ;
        default: st_q <= ST_HDR_ADDR;
      endcase

      if (row_done) begin
        if (last_row) begin
          row_q <= '0;
          if (last_blk) begin
            done_q <= 1'b1;
            st_q   <= ST_HDR_ADDR;
          end else begin
            left_q <= left_q - 8'd1;
            blk_q  <= blk_nxt;
            st_q   <= ST_VEC;
          end
        end else begin
          row_q <= row_q + ROW_W'(1);
          st_q  <= ST_VEC;
        end
      end
    end
  end

  assert_zero_cnt_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_HDR_CNT && fire && data_i == 8'd0) |=> done_o);

  assert_data_sel_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_DATA) |-> vec_q != '0);

  assert_rd_stall_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_VEC && fire && data_i != 8'd0) |=> !ready_o);

  assert_row_step_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_o && !last_row) |=> row_q == $past(row_q) + ROW_W'(1));

  assert_done_pulse_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
endmodule

// File: rtl/cfgv_loader.sv
module cfgv_loader import cfgv_pkg::*; #(
  parameter int NUM_BLOCKS  = 8,
  parameter int FRAME_BYTES = 56,
  localparam int BLK_W      = $clog2(NUM_BLOCKS),
  localparam int ROW_W      = $clog2(FRAME_BYTES),
  localparam int DEPTH      = NUM_BLOCKS * FRAME_BYTES,
  localparam int IDX_W      = $clog2(DEPTH)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                cfg_valid_i,
  input  logic [7:0]          cfg_data_i,
  output logic                cfg_ready_o,
  output logic                done_o,
  input  logic [BLK_W-1:0]    peek_blk_i,
  input  logic [ROW_W-1:0]    peek_row_i,
  output logic [ROW_BITS-1:0] peek_row_o
);
  logic              ld, put, wr;
  logic [LANE_W-1:0] lane;
  logic [IDX_W-1:0]  idx, peek_idx;
  logic [ROW_BITS-1:0] rd_row, stage_row, store_peek;
  logic              peek_hit;

  cfgv_seq #(.NUM_BLOCKS(NUM_BLOCKS), .FRAME_BYTES(FRAME_BYTES)) u_seq (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .valid_i (cfg_valid_i),
    .data_i  (cfg_data_i),
    .ready_o (cfg_ready_o),
    .done_o  (done_o),
    .ld_o    (ld),
    .put_o   (put),
    .lane_o  (lane),
    .wr_o    (wr),
    .idx_o   (idx)
  );

  cfgv_row_stage u_stage (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .ld_i   (ld),
    .row_i  (rd_row),
    .put_i  (put),
    .lane_i (lane),
    .byte_i (cfg_data_i),
    .row_o  (stage_row)
  );

  cfgv_frame_store #(.DEPTH(DEPTH), .ROW_BITS(ROW_BITS)) u_store (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_i       (wr),
    .wr_idx_i   (idx),
    .wr_row_i   (stage_row),
    .rd_idx_i   (idx),
    .rd_row_o   (rd_row),
    .peek_idx_i (peek_idx),
    .peek_row_o (store_peek)
  );

  assign peek_hit   = (int'(peek_blk_i) < NUM_BLOCKS) && (int'(peek_row_i) < FRAME_BYTES);
  assign peek_idx   = IDX_W'(peek_blk_i) * IDX_W'(FRAME_BYTES) + IDX_W'(peek_row_i);
  assign peek_row_o = peek_hit ? store_peek : '0;

  // no byte is consumed while storage is being written
  assert_no_take_on_wr_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr |-> !cfg_ready_o);
endmodule

// File: tb/test_cfgv_loader.sv
`timescale 1ns/1ps
module test_cfgv_loader;
  localparam int NB = 8;
  localparam int FB = 56;
  localparam int BW = 3;
  localparam int RW = 6;

  logic clk = 0, rst_n = 0;
  logic cfg_valid = 0;
  logic [7:0] cfg_data = 0;
  logic cfg_ready, done;
  logic [BW-1:0] peek_blk = 0;
  logic [RW-1:0] peek_row = 0;
  logic [63:0] peek_data;

  logic [63:0] model [NB*FB];
  int checks = 0, fails = 0, done_cnt = 0, cyc = 0;
  bit gap_en = 0;

  always #2.5 clk = ~clk;

  cfgv_loader #(.NUM_BLOCKS(NB), .FRAME_BYTES(FB)) i_cfgv_loader (
    .clk_i(clk), .rst_ni(rst_n), .cfg_valid_i(cfg_valid), .cfg_data_i(cfg_data),
    .cfg_ready_o(cfg_ready), .done_o(done), .peek_blk_i(peek_blk),
    .peek_row_i(peek_row), .peek_row_o(peek_data));

  always @(negedge clk) if (rst_n && done) done_cnt++;

  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000) begin
      fails++; checks++;
      $display("FAIL watchdog act=%0d exp<190000", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic send(input logic [7:0] b);
    if (gap_en) repeat ($urandom % 3) @(negedge clk);
    @(negedge clk);
    cfg_valid = 1; cfg_data = b;
    while (!cfg_ready) @(negedge clk);   // R10: held until taken
    @(posedge clk);
    #1 cfg_valid = 0; cfg_data = 8'h00;
  endtask

  task automatic do_row(int blk, int row, logic [7:0] vec);
    send(vec);
    for (int l = 0; l < 8; l++) begin
      if (vec[l]) begin
        logic [7:0] d;
        d = 8'($urandom);
        send(d);
        model[blk*FB + row][l*8 +: 8] = d;
      end
    end
  endtask

  function automatic logic [7:0] pick_vec();
    int r;
    r = $urandom % 10;
    if (r < 3) return 8'h00;
    if (r == 3) return 8'hFF;
    return 8'($urandom);
  endfunction

  task automatic compare_all(string req);
    int bad;
    bad = 0;
    for (int b = 0; b < NB; b++) begin
      for (int r = 0; r < FB; r++) begin
        peek_blk = BW'(b); peek_row = RW'(r);
        #0.01;
        if (peek_data !== model[b*FB + r]) begin
          bad++;
          if (bad < 4) $display("FAIL %s row b%0d r%0d act=%h exp=%h", req, b, r, peek_data, model[b*FB + r]);
        end
      end
    end
    checks++;
    if (bad != 0) fails++;
  endtask

  // full transfer; start byte upper bits are noise (R2)
  task automatic transfer(int start_raw, int cnt, bit end_nonzero);
    send(8'(start_raw)); send(8'(cnt));
    for (int b = 0; b < cnt; b++) begin
      int blk;
      blk = ((start_raw % NB) + b) % NB;   // R2/R8 wrap
      for (int r = 0; r < FB; r++) begin
        logic [7:0] v;
        v = pick_vec();
        if (end_nonzero && b == cnt - 1 && r == FB - 1 && v == 0) v = 8'h10;
        do_row(blk, r, v);
      end
    end
  endtask

  initial begin
    int d0;
    void'($urandom(32'd4242));
    for (int i = 0; i < NB*FB; i++) model[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 ready", 64'(cfg_ready), 64'd1);
    chk("R1 done", 64'(done), 64'd0);
    compare_all("R1 storage zero");

    // R3 zero count
    d0 = done_cnt;
    send(8'h03); send(8'h00);
    @(negedge clk);
    chk("R3 done after zero count", 64'(done), 64'd1);
    chk("R9 ready with done", 64'(cfg_ready), 64'd1);
    @(negedge clk);
    chk("R3 single done", 64'(done_cnt - d0), 64'd1);
    compare_all("R3 storage unchanged");

    // R4/R7 full row, stalls
    send(8'h02); send(8'd1);
    send(8'hFF);
    @(negedge clk); chk("R7 read stall", 64'(cfg_ready), 64'd0);
    @(negedge clk); chk("R7 read stall one cycle", 64'(cfg_ready), 64'd1);
    for (int l = 0; l < 8; l++) begin
      send(8'(8'h10 + l));
      model[2*FB][l*8 +: 8] = 8'(8'h10 + l);
    end
    @(negedge clk); chk("R7 write stall", 64'(cfg_ready), 64'd0);
    @(negedge clk); chk("R7 write stall one cycle", 64'(cfg_ready), 64'd1);
    send(8'h00);
    @(negedge clk); chk("R6 skip no stall", 64'(cfg_ready), 64'd1);
    for (int r = 2; r < FB - 1; r++) do_row(2, r, 8'h00);
    d0 = done_cnt;
    send(8'h81); send(8'hA0); send(8'hA7);
    model[2*FB + FB-1][7:0] = 8'hA0; model[2*FB + FB-1][63:56] = 8'hA7;
    @(negedge clk);
    chk("R7 last write stall", 64'(cfg_ready), 64'd0);
    chk("R9 no early done", 64'(done), 64'd0);
    @(negedge clk);
    chk("R9 done after write", 64'(done), 64'd1);
    chk("R9 ready with done", 64'(cfg_ready), 64'd1);
    chk("R4 lane order", peek_data, 64'h0);
    compare_all("R4 full row");

    // R5 partial overwrite, zero last row -> R6 done timing
    send(8'h02); send(8'd1);
    do_row(2, 0, 8'h24);
    for (int r = 1; r < FB - 1; r++) do_row(2, r, 8'h00);
    d0 = done_cnt;
    send(8'h00);
    @(negedge clk);
    chk("R6 done after zero last row", 64'(done), 64'd1);
    compare_all("R5 unselected kept");

    // R2/R8 wrap 7 -> 0, upper address bits ignored
    d0 = done_cnt;
    transfer(8'hFF, 2, 0);
    repeat (3) @(negedge clk);
    chk("R8 done once", 64'(done_cnt - d0), 64'd1);
    compare_all("R2 wrap");

    // R9 collision: next header right behind final write-back
    d0 = done_cnt;
    transfer(5, 1, 1);
    transfer(1, 1, 0);
    repeat (3) @(negedge clk);
    chk("R9 two dones", 64'(done_cnt - d0), 64'd2);
    compare_all("R9 back-to-back");

    // random
    gap_en = 1;
    for (int t = 0; t < 20; t++) begin
      int cnt;
      cnt = 1 + ($urandom % 2);
      d0 = done_cnt;
      transfer(int'($urandom % 256), cnt, bit'($urandom % 2));
      repeat (3) @(negedge clk);
      chk("R9 random done", 64'(done_cnt - d0), 64'd1);
      compare_all("R4 random");
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule